// File: doc/BRIEF.md
# Turn-around and False-EOP Timer

This block times the response window on a full- or low-speed serial bus link. Once the local end finishes sending a packet (the SE0-to-J step that closes its end-of-packet), a counter advances on every bit-time strobe. A start-of-packet from the far end (the Idle-to-K step) stops it. If no response begins before a parameterised number of bit times, a timeout flag is raised and held until the next transmitted packet ends.

On the receive side, the block covers the case where a data packet arrives with a bad CRC, which may mean it was cut short by a false end-of-packet. The block then requires a run of quiet bit times before the next token may go out. If any line transition appears inside that run, the block waits for the rest of the stray packet to end and starts the quiet run again from that end. A received packet with a good CRC adds no wait.

The bit-time strobe is supplied at the speed of the current transaction, so one build serves both speeds. The token-permit output is the single gate that the transaction engine consults before it sends a token.

Top module: `bta_timer`

## Requirements
- R1: After reset, `ta_timeout` is 0, `tok_ok` is 1 and `drain_wait` is 0.
- R2: A pulse on `tx_eop_end` starts the response count from zero, and `tok_ok` is 0 from the next cycle while the count runs.
- R3: An `rx_sop` pulse while the count runs stops it with no timeout, `tok_ok` returns to 1 on the next cycle, and later bit strobes raise no timeout.
- R4: With no `rx_sop`, `ta_timeout` becomes 1 in the cycle after the TA_LIMIT-th bit strobe that follows `tx_eop_end`. It stays 1 through further strobes and `rx_sop` pulses, and is cleared only by the next `tx_eop_end`.
- R5: While a response is awaited, `tok_ok` stays 0 until the full TA_LIMIT bit strobes have elapsed, even when the run ends in a timeout.
- R6: `rx_eop_end` with `rx_bad` = 1 drops `tok_ok` to 0. `tok_ok` returns to 1 after QUIET_BITS bit strobes that carry no `bus_edge`, and not after QUIET_BITS-1.
- R7: A `bus_edge` pulse during the quiet run sets `drain_wait` to 1 and keeps `tok_ok` at 0, whatever the number of later bit strobes.
- R8: While `drain_wait` is 1, any `rx_eop_end` clears `drain_wait` and restarts a full quiet run of QUIET_BITS strobes before `tok_ok` is 1.
- R9: `rx_eop_end` with `rx_bad` = 0 from the idle state leaves `tok_ok` at 1 and `drain_wait` at 0.
- R10: In the same cycle, `rx_sop` overrides the final timeout strobe (no timeout), and `bus_edge` overrides the final quiet strobe (`drain_wait` = 1).
- R11: Clock cycles without `bit_tick` advance neither count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time at the current speed |
| tx_eop_end | input | 1 | SE0-to-J step ending a locally transmitted packet |
| rx_sop | input | 1 | Idle-to-K step starting a received packet |
| rx_eop_end | input | 1 | SE0-to-J step ending a received packet |
| rx_bad | input | 1 | Received data packet failed its check, valid with rx_eop_end |
| bus_edge | input | 1 | Any line transition seen |
| ta_timeout | output | 1 | Response window expired, held until next transmit end |
| tok_ok | output | 1 | Next token may be issued |
| drain_wait | output | 1 | Waiting for a stray packet to finish |

## Verification
Two pairs of events can fall in the same cycle, and each is a race between a terminating event and a count's final step. The first pair is a start-of-packet and the last timeout strobe. The bench drives `rx_sop` and `bit_tick` together on the TA_LIMIT-th strobe and expects no timeout and an open token gate. The second pair is a line transition and the last quiet strobe. The bench drives `bus_edge` with the QUIET_BITS-th strobe and expects `drain_wait` high and the gate shut, then confirms that only a later packet end and a fresh quiet run reopen it.

// File: rtl/bta_pkg.sv
package bta_pkg;

  typedef enum logic [1:0] {
    QW_IDLE  = 2'd0,
    QW_QUIET = 2'd1,
    QW_DRAIN = 2'd2
  } qwait_e;

  // Saturating increment: never exceeds lim.
  function automatic logic [15:0] sat_inc(input logic [15:0] v, input logic [15:0] lim);
    return (v >= lim) ? lim : v + 16'd1;
  endfunction

  // True when one more step lands on (or past) the limit.
  function automatic logic step_hits(input logic [15:0] v, input logic [15:0] lim);
    return (v + 16'd1) >= lim;
  endfunction

endpackage

// File: rtl/bta_turnaround.sv
module bta_turnaround
  import bta_pkg::*;
#(
  parameter int TA_LIMIT = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_eop_end,
  input  logic rx_sop,
  output logic ta_armed,
  output logic ta_timeout
);

  localparam int CW = $clog2(TA_LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          to_q;

  // Named internal events
  logic ta_start, ta_stop, ta_step, ta_expire;
  assign ta_start  = tx_eop_end;
  assign ta_stop   = armed_q & rx_sop;
  assign ta_step   = armed_q & bit_tick & ~rx_sop;
  assign ta_expire = ta_step & step_hits(16'(cnt_q), 16'(TA_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      to_q    <= 1'b0;
    end else if (ta_start) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      to_q    <= 1'b0;
    end else if (ta_stop) begin
      armed_q <= 1'b0;
    end else if (ta_step) begin
      cnt_q <= CW'(sat_inc(16'(cnt_q), 16'(TA_LIMIT)));
      if (ta_expire) begin
        armed_q <= 1'b0;
        to_q    <= 1'b1;
      end
    end
  end

  assign ta_armed   = armed_q;
  assign ta_timeout = to_q;

  AST_TA_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) <= TA_LIMIT); // R4

  AST_TIMEOUT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_q) |-> (32'(cnt_q) == TA_LIMIT)); // R4

  AST_SOP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && rx_sop && !tx_eop_end) |=> (!armed_q && !to_q)); // R3

  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_tick && !tx_eop_end) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/bta_quiet.sv
module bta_quiet
  import bta_pkg::*;
#(
  parameter int QUIET_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic rx_eop_end,
  input  logic rx_bad,
  input  logic bus_edge,
  output logic qw_busy,
  output logic qw_drain
);

  localparam int QW = $clog2(QUIET_BITS + 1);

  qwait_e        st_q;
  logic [QW-1:0] qcnt_q;

  // Named internal events
  logic qw_enter, qw_break, qw_step, qw_done;
  assign qw_enter = rx_eop_end & (rx_bad | (st_q == QW_DRAIN));
  assign qw_break = (st_q == QW_QUIET) & bus_edge;
  assign qw_step  = (st_q == QW_QUIET) & bit_tick & ~bus_edge;
  assign qw_done  = qw_step & step_hits(16'(qcnt_q), 16'(QUIET_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= QW_IDLE;
      qcnt_q <= '0;
    end else if (qw_enter) begin
      st_q   <= QW_QUIET;
      qcnt_q <= '0;
    end else if (qw_break) begin
      st_q <= QW_DRAIN;
    end else if (qw_step) begin
      qcnt_q <= QW'(sat_inc(16'(qcnt_q), 16'(QUIET_BITS)));
      if (qw_done) st_q <= QW_IDLE;
    end
  end

  assign qw_busy  = (st_q != QW_IDLE);
  assign qw_drain = (st_q == QW_DRAIN);

  AST_EDGE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == QW_QUIET) && bus_edge && !rx_eop_end) |=> (st_q == QW_DRAIN)); // R7

  AST_DRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == QW_DRAIN) && !rx_eop_end) |=> (st_q == QW_DRAIN)); // R7

  AST_DRAIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == QW_DRAIN) && rx_eop_end) |=> ((st_q == QW_QUIET) && (qcnt_q == '0))); // R8

  AST_GOOD_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == QW_IDLE) && rx_eop_end && !rx_bad) |=> (st_q == QW_IDLE)); // R9

  AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(qcnt_q) < QUIET_BITS || st_q != QW_QUIET); // R6

endmodule

// File: rtl/bta_timer.sv
module bta_timer
  import bta_pkg::*;
#(
  parameter int TA_LIMIT   = 18,
  parameter int QUIET_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_eop_end,
  input  logic rx_sop,
  input  logic rx_eop_end,
  input  logic rx_bad,
  input  logic bus_edge,
  output logic ta_timeout,
  output logic tok_ok,
  output logic drain_wait
);

  logic ta_armed;
  logic qw_busy;
  logic qw_drain;

  bta_turnaround #(.TA_LIMIT(TA_LIMIT)) u_ta (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .tx_eop_end(tx_eop_end),
    .rx_sop    (rx_sop),
    .ta_armed  (ta_armed),
    .ta_timeout(ta_timeout)
  );

  bta_quiet #(.QUIET_BITS(QUIET_BITS)) u_qw (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .rx_eop_end(rx_eop_end),
    .rx_bad    (rx_bad),
    .bus_edge  (bus_edge),
    .qw_busy   (qw_busy),
    .qw_drain  (qw_drain)
  );

  assign tok_ok     = ~ta_armed & ~qw_busy;
  assign drain_wait = qw_drain;

  AST_TX_GATES_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_eop_end |=> !tok_ok); // R2

  AST_BAD_GATES_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eop_end && rx_bad) |=> !tok_ok); // R6

  AST_TIMEOUT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ta_timeout) && !qw_busy) |-> tok_ok); // R5

endmodule

// File: tb/bta_timer_bench.sv
module bta_timer_bench;

  localparam int LIM = 18;
  localparam int QB  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, tx_eop_end = 1'b0, rx_sop = 1'b0;
  logic rx_eop_end = 1'b0, rx_bad = 1'b0, bus_edge = 1'b0;
  logic ta_timeout, tok_ok, drain_wait;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bta_timer #(.TA_LIMIT(LIM), .QUIET_BITS(QB)) u_bta_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_eop_end(tx_eop_end),
    .rx_sop(rx_sop), .rx_eop_end(rx_eop_end), .rx_bad(rx_bad), .bus_edge(bus_edge),
    .ta_timeout(ta_timeout), .tok_ok(tok_ok), .drain_wait(drain_wait)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  // Each bit strobe is one cycle high, then three idle cycles.
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic tx_end();
    tx_eop_end = 1'b1; @(negedge clk); tx_eop_end = 1'b0;
  endtask

  task automatic sop();
    rx_sop = 1'b1; @(negedge clk); rx_sop = 1'b0;
  endtask

  task automatic rx_end(input logic bad);
    rx_eop_end = 1'b1; rx_bad = bad; @(negedge clk);
    rx_eop_end = 1'b0; rx_bad = 1'b0;
  endtask

  task automatic edge_pulse();
    bus_edge = 1'b1; @(negedge clk); bus_edge = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "ta_timeout", ta_timeout, 1'b0);
    chk("R1", "tok_ok", tok_ok, 1'b1);
    chk("R1", "drain_wait", drain_wait, 1'b0);
  endtask

  task automatic t_response();
    tx_end();
    chk("R2", "tok_ok after tx end", tok_ok, 1'b0);
    ticks(5);
    repeat (40) @(negedge clk);
    chk("R11", "no timeout without strobes", ta_timeout, 1'b0);
    chk("R11", "gate still shut", tok_ok, 1'b0);
    ticks(LIM - 6);
    chk("R11", "no timeout at LIM-1 strobes", ta_timeout, 1'b0);
    sop();
    chk("R3", "tok_ok after sop", tok_ok, 1'b1);
    chk("R3", "timeout after sop", ta_timeout, 1'b0);
    ticks(LIM + 5);
    chk("R3", "no later timeout", ta_timeout, 1'b0);
  endtask

  task automatic t_timeout();
    tx_end();
    ticks(LIM - 1);
    chk("R5", "gate shut before limit", tok_ok, 1'b0);
    chk("R4", "no timeout before limit", ta_timeout, 1'b0);
    ticks(1);
    chk("R4", "timeout at limit", ta_timeout, 1'b1);
    chk("R5", "gate open at limit", tok_ok, 1'b1);
    ticks(4);
    sop();
    chk("R4", "timeout held", ta_timeout, 1'b1);
    tx_end();
    chk("R4", "timeout cleared by tx end", ta_timeout, 1'b0);
    sop();
  endtask

  task automatic t_sop_race();
    tx_end();
    ticks(LIM - 1);
    rx_sop = 1'b1; bit_tick = 1'b1;
    @(negedge clk);
    rx_sop = 1'b0; bit_tick = 1'b0;
    chk("R10", "sop beats last strobe, timeout", ta_timeout, 1'b0);
    chk("R10", "sop beats last strobe, gate", tok_ok, 1'b1);
  endtask

  task automatic t_bad_quiet();
    rx_end(1'b1);
    chk("R6", "gate shut after bad packet", tok_ok, 1'b0);
    chk("R6", "no drain yet", drain_wait, 1'b0);
    ticks(QB - 1);
    chk("R6", "gate shut at QB-1", tok_ok, 1'b0);
    ticks(1);
    chk("R6", "gate open at QB", tok_ok, 1'b1);
  endtask

  task automatic t_good();
    rx_end(1'b0);
    chk("R9", "gate after good packet", tok_ok, 1'b1);
    chk("R9", "drain after good packet", drain_wait, 1'b0);
  endtask

  task automatic t_drain();
    rx_end(1'b1);
    ticks(4);
    edge_pulse();
    chk("R7", "drain after edge", drain_wait, 1'b1);
    ticks(3 * QB);
    chk("R7", "drain held", drain_wait, 1'b1);
    chk("R7", "gate shut in drain", tok_ok, 1'b0);
    rx_end(1'b0);
    chk("R8", "drain cleared by packet end", drain_wait, 1'b0);
    chk("R8", "gate shut on restart", tok_ok, 1'b0);
    ticks(QB - 1);
    chk("R8", "gate shut at QB-1 after restart", tok_ok, 1'b0);
    ticks(1);
    chk("R8", "gate open after full restart", tok_ok, 1'b1);
  endtask

  task automatic t_edge_race();
    rx_end(1'b1);
    ticks(QB - 1);
    bus_edge = 1'b1; bit_tick = 1'b1;
    @(negedge clk);
    bus_edge = 1'b0; bit_tick = 1'b0;
    chk("R10", "edge beats last strobe, drain", drain_wait, 1'b1);
    chk("R10", "edge beats last strobe, gate", tok_ok, 1'b0);
    rx_end(1'b0);
    ticks(QB);
    chk("R8", "gate open after drain recovery", tok_ok, 1'b1);
  endtask

  task automatic t_quiet_no_tick();
    rx_end(1'b1);
    repeat (60) @(negedge clk);
    chk("R11", "quiet run needs strobes", tok_ok, 1'b0);
    ticks(QB);
    chk("R11", "gate open after strobes", tok_ok, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_response();
    t_timeout();
    t_sop_race();
    t_bad_quiet();
    t_good();
    t_drain();
    t_edge_race();
    t_quiet_no_tick();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule